// File: doc/BRIEF.md
# Sequential Buffer Address Pointer

This block is the clocked side of a buffer memory that is filled or drained in address order while another port reaches it at random. It keeps a 12-bit address pointer. On every clock edge the pointer can:

- step up by one;
- take a value that was captured from the data bus one cycle earlier;
- jump to one of two start addresses held by the command side.

Two end-of-buffer flags watch the pointer. A flag drops when an increment lands on its end address. It stays low until reset, or until the command side clears it.

The block also registers the chip select, read/write and output enable controls of the port. From them it produces the array address, a write strobe and a read enable for the memory array, which sits outside this block. Every access launched at an edge is addressed with the pointer value held before that edge updates it. A protocol-error output reports a start jump requested while a load is being captured or is still pending.

Top module: `seq_ptr_unit`

## Requirements
- R1: At a rising edge with `cnt_en_n` low, and no pending load or start jump, `ptr_o` becomes its old value plus one. It wraps from 4095 to 0.
- R2: At an edge with `load_n` low, `load_val` is captured. At the following edge `ptr_o` takes the captured value. Asserting `load_n` does not stop an increment at the edge where the value is captured.
- R3: At an edge with `jump1_n` low, `ptr_o` takes `start1`. At an edge with only `jump2_n` low, it takes `start2`. If both are low, `start1` wins.
- R4: The pointer update has a fixed priority: the pending load first, then a start jump, then the increment.
- R5: `eob1_n` goes low after an edge where an increment makes the pointer equal to `end1`. `eob2_n` does the same against `end2`. Each flag reacts only to its own end address.
- R6: A load or a start jump that lands on an end address leaves that end-of-buffer flag unchanged.
- R7: A low flag stays low until reset or until a high `clr1`/`clr2` at an edge returns it high. If a matching increment and a clear fall on the same edge, the flag is low.
- R8: `proto_err` is high for the one cycle after an edge where either start strobe was low while `load_n` was low or a load was pending. Otherwise it is low.
- R9: `mem_we` is high after an edge with `sel_n` and `wr_n` both low. It is low after an edge where either of them is high.
- R10: `mem_re` is high after an edge with `sel_n` low, `wr_n` high and `oe_n` low. Otherwise it is low.
- R11: After each edge, `mem_addr` holds the value `ptr_o` had before that edge.
- R12: While `rst_n` is low, and without waiting for a clock, the following hold: `ptr_o` and `mem_addr` are 0, both flags are high, `mem_we`, `mem_re` and `proto_err` are low, and no load is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en_n | input | 1 | Increment request, active low |
| load_n | input | 1 | Capture `load_val` for a delayed pointer load, active low |
| jump1_n | input | 1 | Jump to `start1`, active low |
| jump2_n | input | 1 | Jump to `start2`, active low |
| sel_n | input | 1 | Port chip select, active low |
| wr_n | input | 1 | Low selects a write, high a read |
| oe_n | input | 1 | Output enable for reads, active low |
| load_val | input | 12 | Low bits of the data bus used as a load address |
| start1 | input | 12 | Start address of buffer 1 |
| start2 | input | 12 | Start address of buffer 2 |
| end1 | input | 12 | End address of buffer 1 |
| end2 | input | 12 | End address of buffer 2 |
| clr1 | input | 1 | Clear strobe for the buffer 1 flag |
| clr2 | input | 1 | Clear strobe for the buffer 2 flag |
| ptr_o | output | 12 | Current pointer value |
| mem_addr | output | 12 | Array address of the access launched at the last edge |
| mem_we | output | 1 | Array write strobe |
| mem_re | output | 1 | Array read enable |
| eob1_n | output | 1 | Buffer 1 end flag, active low |
| eob2_n | output | 1 | Buffer 2 end flag, active low |
| proto_err | output | 1 | Start jump during a load capture or pending load |

## Verification
The end-of-buffer properties compare the pointer with the present end addresses, so they assume `end1`, `end2` and the start addresses hold steady while the pointer is moving. The stimulus writes them only during reset or while the port is idle. All control inputs are driven to known levels from time zero, so the first sampled edge after reset sees defined values. Start-strobe clashes with a load are driven deliberately, but only in the steps that check R4 and R8. Every other step keeps the strobes apart from a load and the cycle after it.

// File: rtl/seq_ptr_pkg.sv
package seq_ptr_pkg;

    localparam int unsigned PTR_W = 12;
    localparam int unsigned NBUF  = 2;

    // Which source updated the pointer at an edge, in priority order
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_INC  = 2'd1,
        SRC_JUMP = 2'd2,
        SRC_LOAD = 2'd3
    } ptr_src_e;

endpackage

// File: rtl/seq_ptr_core.sv
module seq_ptr_core
    import seq_ptr_pkg::*;
#(
    parameter int unsigned AW = PTR_W,
    parameter int unsigned NB = NBUF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 inc_req,
    input  logic                 load_req,
    input  logic [NB-1:0]        jump_req,
    input  logic [AW-1:0]        load_val,
    input  logic [NB-1:0][AW-1:0] start_addr,
    output logic [AW-1:0]        ptr,
    output logic [AW-1:0]        ptr_nx,
    output logic                 pend,
    output logic [AW-1:0]        din,
    output logic                 inc_taken
);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [AW-1:0] din;
        logic          pend;
    } core_state_t;

    core_state_t st_d, st_q;
    ptr_src_e    src;
    logic        jump_hit;
    logic [AW-1:0] jump_val;

    // Lowest-numbered start strobe wins
    always_comb begin
        jump_hit = 1'b0;
        jump_val = '0;
        for (int i = int'(NB) - 1; i >= 0; i--) begin
            if (jump_req[i]) begin
                jump_hit = 1'b1;
                jump_val = start_addr[i];
            end
        end
    end

    always_comb begin
        st_d = st_q;

        if (st_q.pend)     src = SRC_LOAD;
        else if (jump_hit) src = SRC_JUMP;
        else if (inc_req)  src = SRC_INC;
        else               src = SRC_HOLD;

        unique case (src)
            SRC_LOAD: st_d.ptr = st_q.din;
            SRC_JUMP: st_d.ptr = jump_val;
            SRC_INC:  st_d.ptr = st_q.ptr + AW'(1);
            default:  st_d.ptr = st_q.ptr;
        endcase

        // A fresh capture may overlap the application of the previous one
        st_d.pend = load_req;
        if (load_req) st_d.din = load_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr       = st_q.ptr;
    assign ptr_nx    = st_d.ptr;
    assign pend      = st_q.pend;
    assign din       = st_q.din;
    assign inc_taken = (src == SRC_INC);

endmodule

// File: rtl/seq_eob_flags.sv
module seq_eob_flags
    import seq_ptr_pkg::*;
#(
    parameter int unsigned AW = PTR_W,
    parameter int unsigned NB = NBUF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc_taken,
    input  logic [AW-1:0]         ptr_nx,
    input  logic [NB-1:0][AW-1:0] end_addr,
    input  logic [NB-1:0]         clr,
    output logic [NB-1:0]         eob_n
);

    typedef struct packed {
        logic [NB-1:0] hit;
    } flag_state_t;

    flag_state_t fl_d, fl_q;
    logic [NB-1:0] reach;

    generate
        for (genvar g = 0; g < NB; g++) begin : g_cmp
            assign reach[g] = inc_taken && (ptr_nx == end_addr[g]);
        end
    endgenerate

    always_comb begin
        fl_d = fl_q;
        for (int i = 0; i < int'(NB); i++) begin
            if (reach[i])    fl_d.hit[i] = 1'b1;
            else if (clr[i]) fl_d.hit[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign eob_n = ~fl_q.hit;

endmodule

// File: rtl/seq_access_ctrl.sv
module seq_access_ctrl
    import seq_ptr_pkg::*;
#(
    parameter int unsigned AW = PTR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic          oe,
    input  logic          jump_any,
    input  logic          load_req,
    input  logic          pend,
    input  logic [AW-1:0] ptr,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic          proto_err
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          we;
        logic          re;
        logic          perr;
    } acc_state_t;

    acc_state_t ac_d, ac_q;

    always_comb begin
        ac_d      = ac_q;
        ac_d.addr = ptr;
        ac_d.we   = sel && wr;
        ac_d.re   = sel && !wr && oe;
        ac_d.perr = jump_any && (load_req || pend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ac_q <= '0;
        else        ac_q <= ac_d;
    end

    assign mem_addr  = ac_q.addr;
    assign mem_we    = ac_q.we;
    assign mem_re    = ac_q.re;
    assign proto_err = ac_q.perr;

endmodule

// File: rtl/seq_ptr_unit.sv
module seq_ptr_unit
    import seq_ptr_pkg::*;
#(
    parameter int unsigned AW = PTR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en_n,
    input  logic          load_n,
    input  logic          jump1_n,
    input  logic          jump2_n,
    input  logic          sel_n,
    input  logic          wr_n,
    input  logic          oe_n,
    input  logic [AW-1:0] load_val,
    input  logic [AW-1:0] start1,
    input  logic [AW-1:0] start2,
    input  logic [AW-1:0] end1,
    input  logic [AW-1:0] end2,
    input  logic          clr1,
    input  logic          clr2,
    output logic [AW-1:0] ptr_o,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic          eob1_n,
    output logic          eob2_n,
    output logic          proto_err
);

    localparam int unsigned NB = 2;

    logic [NB-1:0]         jump_req;
    logic [NB-1:0][AW-1:0] start_addr;
    logic [NB-1:0][AW-1:0] end_addr;
    logic [NB-1:0]         clr;
    logic [NB-1:0]         eob_n;
    logic [AW-1:0]         ptr_nx;
    logic                  pend_q;
    logic [AW-1:0]         din_q;
    logic                  inc_taken;

    assign jump_req   = {~jump2_n, ~jump1_n};
    assign start_addr = {start2, start1};
    assign end_addr   = {end2, end1};
    assign clr        = {clr2, clr1};

    seq_ptr_core #(.AW(AW), .NB(NB)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_req    (~cnt_en_n),
        .load_req   (~load_n),
        .jump_req   (jump_req),
        .load_val   (load_val),
        .start_addr (start_addr),
        .ptr        (ptr_o),
        .ptr_nx     (ptr_nx),
        .pend       (pend_q),
        .din        (din_q),
        .inc_taken  (inc_taken)
    );

    seq_eob_flags #(.AW(AW), .NB(NB)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_taken (inc_taken),
        .ptr_nx    (ptr_nx),
        .end_addr  (end_addr),
        .clr       (clr),
        .eob_n     (eob_n)
    );

    seq_access_ctrl #(.AW(AW)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (~sel_n),
        .wr        (~wr_n),
        .oe        (~oe_n),
        .jump_any  (|jump_req),
        .load_req  (~load_n),
        .pend      (pend_q),
        .ptr       (ptr_o),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .proto_err (proto_err)
    );

    assign eob1_n = eob_n[0];
    assign eob2_n = eob_n[1];

endmodule

// File: rtl/seq_ptr_chk.sv
module seq_ptr_chk #(
    parameter int unsigned AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_en_n,
    input logic          load_n,
    input logic          jump1_n,
    input logic          jump2_n,
    input logic          sel_n,
    input logic          wr_n,
    input logic          oe_n,
    input logic [AW-1:0] start1,
    input logic [AW-1:0] end1,
    input logic [AW-1:0] end2,
    input logic [AW-1:0] ptr_o,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          mem_re,
    input logic          eob1_n,
    input logic          eob2_n,
    input logic          proto_err,
    input logic          pend,
    input logic [AW-1:0] din
);

    // R1
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_n && !pend && jump1_n && jump2_n) |=> (ptr_o == AW'($past(ptr_o) + AW'(1))));

    // R2
    load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> (ptr_o == $past(din)));

    // R3
    jump1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !jump1_n) |=> (ptr_o == $past(start1)));

    // R5
    eob1_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eob1_n) |-> ((ptr_o == end1) && $past(!cnt_en_n && !pend && jump1_n && jump2_n)));

    // R5
    eob2_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eob2_n) |-> ((ptr_o == end2) && $past(!cnt_en_n && !pend && jump1_n && jump2_n)));

    // R8
    perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(jump1_n && jump2_n) && (!load_n || pend)) |=> proto_err);

    // R9
    we_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_n) |=> mem_we);

    // R9
    we_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || wr_n) |=> !mem_we);

    // R10
    re_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && wr_n && !oe_n) |=> mem_re);

    // R11
    addr_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem_addr == $past(ptr_o)));

endmodule

bind seq_ptr_unit seq_ptr_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en_n  (cnt_en_n),
    .load_n    (load_n),
    .jump1_n   (jump1_n),
    .jump2_n   (jump2_n),
    .sel_n     (sel_n),
    .wr_n      (wr_n),
    .oe_n      (oe_n),
    .start1    (start1),
    .end1      (end1),
    .end2      (end2),
    .ptr_o     (ptr_o),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .eob1_n    (eob1_n),
    .eob2_n    (eob2_n),
    .proto_err (proto_err),
    .pend      (pend_q),
    .din       (din_q)
);

// File: tb/seq_ptr_unit_test.sv
`timescale 1ns/1ps
module seq_ptr_unit_test;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_en_n = 1'b1, load_n = 1'b1, jump1_n = 1'b1, jump2_n = 1'b1;
    logic          sel_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] load_val = '0;
    logic [AW-1:0] start1 = 12'd5, start2 = 12'd100, end1 = 12'd10, end2 = 12'd20;
    logic          clr1 = 1'b0, clr2 = 1'b0;
    logic [AW-1:0] ptr_o, mem_addr;
    logic          mem_we, mem_re, eob1_n, eob2_n, proto_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    seq_ptr_unit #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .load_n(load_n),
        .jump1_n(jump1_n), .jump2_n(jump2_n), .sel_n(sel_n), .wr_n(wr_n),
        .oe_n(oe_n), .load_val(load_val), .start1(start1), .start2(start2),
        .end1(end1), .end2(end2), .clr1(clr1), .clr2(clr2), .ptr_o(ptr_o),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .eob1_n(eob1_n), .eob2_n(eob2_n), .proto_err(proto_err)
    );

    typedef struct {
        string         tag;
        logic [AW-1:0] ptr;
        logic [AW-1:0] addr;
        logic          we, re, e1n, e2n, perr;
    } exp_t;

    exp_t exp_q[$];

    // Bench reference state
    logic [AW-1:0] m_ptr = '0, m_din = '0;
    logic          m_pend = 1'b0, m_e1n = 1'b1, m_e2n = 1'b1;

    task automatic chk(string tag, string field, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, field, got, exp);
        end
    endtask

    task automatic model_reset();
        m_ptr = '0; m_din = '0; m_pend = 1'b0; m_e1n = 1'b1; m_e2n = 1'b1;
    endtask

    // Driver: active-high arguments, drives at the falling edge, queues expectation
    task automatic step(string tag, bit inc, bit ld, bit j1, bit j2,
                        bit sel, bit wr, bit rd, logic [AW-1:0] val,
                        bit c1, bit c2);
        exp_t e;
        logic [AW-1:0] nx;
        bit inc_tk;
        @(negedge clk);
        cnt_en_n = ~inc; load_n = ~ld; jump1_n = ~j1; jump2_n = ~j2;
        sel_n = ~sel; wr_n = ~wr; oe_n = ~rd; load_val = val;
        clr1 = c1; clr2 = c2;
        inc_tk = 1'b0;
        if (m_pend)   nx = m_din;
        else if (j1)  nx = start1;
        else if (j2)  nx = start2;
        else if (inc) begin nx = m_ptr + 12'd1; inc_tk = 1'b1; end
        else          nx = m_ptr;
        e.tag  = tag;
        e.addr = m_ptr;
        e.we   = sel && wr;
        e.re   = sel && !wr && rd;
        e.perr = (j1 || j2) && (ld || m_pend);
        if (inc_tk && nx == end1) m_e1n = 1'b0; else if (c1) m_e1n = 1'b1;
        if (inc_tk && nx == end2) m_e2n = 1'b0; else if (c2) m_e2n = 1'b1;
        if (ld) m_din = val;
        m_pend = ld;
        m_ptr  = nx;
        e.ptr = m_ptr; e.e1n = m_e1n; e.e2n = m_e2n;
        exp_q.push_back(e);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, '0, 0, 0);
    endtask

    // Monitor: samples a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "ptr_o",     ptr_o,     e.ptr);
                chk(e.tag, "mem_addr",  mem_addr,  e.addr);
                chk(e.tag, "mem_we",    mem_we,    e.we);
                chk(e.tag, "mem_re",    mem_re,    e.re);
                chk(e.tag, "eob1_n",    eob1_n,    e.e1n);
                chk(e.tag, "eob2_n",    eob2_n,    e.e2n);
                chk(e.tag, "proto_err", proto_err, e.perr);
            end
        end
    end

    task automatic reset_state_check(string tag);
        chk(tag, "ptr_o",     ptr_o,     0);
        chk(tag, "mem_addr",  mem_addr,  0);
        chk(tag, "mem_we",    mem_we,    0);
        chk(tag, "mem_re",    mem_re,    0);
        chk(tag, "eob1_n",    eob1_n,    1);
        chk(tag, "eob2_n",    eob2_n,    1);
        chk(tag, "proto_err", proto_err, 0);
    endtask

    initial begin
        #5;
        reset_state_check("R12");
        #40 rst_n = 1'b1;

        // R1 R9 R11: counting while writing, then write ends
        step("R1_R9", 1, 0, 0, 0, 1, 1, 0, '0, 0, 0);
        step("R1_R9", 1, 0, 0, 0, 1, 1, 0, '0, 0, 0);
        step("R11",   1, 0, 0, 0, 1, 1, 0, '0, 0, 0);
        step("R9",    0, 0, 0, 0, 0, 1, 0, '0, 0, 0);
        // R10: reads, then select without output enable
        step("R10",   1, 0, 0, 0, 1, 0, 1, '0, 0, 0);
        step("R10",   1, 0, 0, 0, 1, 0, 0, '0, 0, 0);
        step("R10",   0, 0, 0, 0, 0, 0, 1, '0, 0, 0);
        // R2: delayed load with a same-edge increment, then wrap (R1)
        step("R2",    1, 1, 0, 0, 0, 0, 0, 12'd4094, 0, 0);
        idle("R2");
        step("R1",    1, 0, 0, 0, 0, 0, 0, '0, 0, 0);
        step("R1",    1, 0, 0, 0, 0, 0, 0, '0, 0, 0);
        // R3: start jumps
        step("R3",    1, 0, 0, 1, 0, 0, 0, '0, 0, 0);
        step("R3",    0, 0, 1, 0, 0, 0, 0, '0, 0, 0);
        step("R3",    0, 0, 1, 1, 0, 0, 0, '0, 0, 0);
        // R5 R7: reach end1 from start1, stay low
        for (int i = 0; i < 5; i++) step("R5", 1, 0, 0, 0, 0, 0, 0, '0, 0, 0);
        step("R7",    1, 0, 0, 0, 0, 0, 0, '0, 0, 0);
        step("R7",    1, 0, 0, 0, 0, 0, 0, '0, 0, 0);
        // R6: load lands on end2, no flag
        step("R6",    0, 1, 0, 0, 0, 0, 0, 12'd20, 0, 0);
        idle("R6");
        step("R6",    0, 0, 1, 0, 0, 0, 0, '0, 0, 0);
        // R7: clear, then clear coinciding with a match
        step("R7",    0, 0, 0, 0, 0, 0, 0, '0, 1, 0);
        step("R7",    0, 1, 0, 0, 0, 0, 0, 12'd9, 0, 0);
        idle("R7");
        step("R7",    1, 0, 0, 0, 0, 0, 0, '0, 1, 0);
        step("R7",    0, 0, 0, 0, 0, 0, 0, '0, 1, 0);
        // R5: buffer 2 flag on its own
        step("R5",    0, 1, 0, 0, 0, 0, 0, 12'd18, 0, 0);
        idle("R5");
        step("R5",    1, 0, 0, 0, 0, 0, 0, '0, 0, 0);
        step("R5",    1, 0, 0, 0, 0, 0, 0, '0, 0, 0);
        step("R7",    0, 0, 0, 0, 0, 0, 0, '0, 0, 1);
        // R4 R8: pending load beats jump and increment; jump beats increment
        step("R4",    0, 1, 0, 0, 0, 0, 0, 12'd50, 0, 0);
        step("R4_R8", 1, 0, 1, 0, 0, 0, 0, '0, 0, 0);
        step("R4",    1, 0, 0, 1, 0, 0, 0, '0, 0, 0);
        // R8: jump with same-edge load, then clean jump
        step("R8",    0, 1, 1, 0, 0, 0, 0, 12'd7, 0, 0);
        idle("R8");
        step("R8",    0, 0, 0, 1, 0, 0, 0, '0, 0, 0);
        idle("R8");
        // R12: asynchronous reset mid-run
        step("R12",   0, 0, 0, 0, 1, 1, 0, '0, 0, 0);
        @(negedge clk);
        #5;
        rst_n = 1'b0;
        #2;
        reset_state_check("R12");
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        step("R12",   1, 0, 0, 0, 0, 0, 0, '0, 0, 0);
        idle("R12");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule